// File: doc/BRIEF.md
# Nanosecond Real-Time Counter with Alarm Interrupt

This block keeps a free-running 64-bit time value in nanoseconds. The value advances by a fixed step on every clock edge. Software reaches it over a narrow synchronous register bus with 32-bit data. The time value is read and written as two 32-bit halves. A 64-bit alarm word is compared against the running time. When the time catches up with the alarm, a sticky pending flag is set. A one-bit enable masks that flag onto a level interrupt line.

Software arms the alarm by writing the upper alarm word first and the lower alarm word last. Only the lower-word write arms the compare. If the stored alarm is already at or behind the current time, the block raises pending at once and does not start a wait. Cancelling a wait leaves any pending event in place. Acknowledging the interrupt is a separate write.

Read data is registered. It appears on the clock edge that samples the read, and holds until the next read.

Top module: `ns_rtc`

## Requirements
- R1: A synchronous reset clears the time, the alarm word, the waiting flag, the pending flag and the enable bit. The first read of offset 0x00 after reset returns 0.
- R2: With no time write in a cycle, the time grows by NS_PER_CLK (default 10) at each clock edge. Offset 0x00 reads bits 31:0 and offset 0x04 reads bits 63:32, and a carry out of the low half reaches the high half.
- R3: A write to 0x00 replaces only bits 31:0 of the time, and a write to 0x04 replaces only bits 63:32. The other half keeps its present value, and that cycle's increment is dropped.
- R4: A write to 0x0C only stores alarm bits 63:32 and does not arm. A write to 0x08 stores alarm bits 31:0 and arms the compare with the full 64-bit word. Reads of 0x08 and 0x0C return the stored halves.
- R5: Arming with an alarm less than or equal to the current time sets pending and leaves waiting at 0.
- R6: Arming with a later alarm sets waiting, and offset 0x18 reads it back as 1. At the first edge where the time is greater than or equal to the alarm, waiting clears and pending sets, so a step that jumps past the exact value still fires.
- R7: The interrupt line is pending AND enable. A write to 0x10 keeps only data bit 0, offset 0x10 reads that bit back, and the line follows from the edge after the write.
- R8: Any write to 0x14 cancels a wait so that no later event occurs, and it leaves pending unchanged.
- R9: Any write to 0x1C clears pending whatever the data. If an alarm event falls in the same cycle, the event wins and pending stays set.
- R10: Offsets other than the eight word-aligned ones above read as 0, and writes to them change nothing. The write-only offsets 0x14 and 0x1C also read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per asserted cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the sampling edge |
| irq | output | 1 | Level interrupt, pending masked by enable |

## Verification
The alarm compare can fire in the same cycle that software writes the acknowledge offset. The bench arms an alarm a known number of steps ahead and counts edges exactly. It then places the 0x1C write on the firing edge and expects the line to stay high. A second acknowledge must drop it. Boundary timing is judged the same way: the line must still be low one edge before the computed match and high one edge after it, both for an alarm that lands on a step and for one that falls between steps.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int WORD_W = 32;
    localparam int HALVES = 2;
    localparam int CNT_W  = WORD_W * HALVES;

    // Byte offsets seen on the register bus
    localparam logic [31:0] OFF_TIME_LO  = 32'h00;
    localparam logic [31:0] OFF_TIME_HI  = 32'h04;
    localparam logic [31:0] OFF_ALM_LO   = 32'h08;
    localparam logic [31:0] OFF_ALM_HI   = 32'h0C;
    localparam logic [31:0] OFF_IRQ_EN   = 32'h10;
    localparam logic [31:0] OFF_ALM_STOP = 32'h14;
    localparam logic [31:0] OFF_ALM_STAT = 32'h18;
    localparam logic [31:0] OFF_IRQ_ACK  = 32'h1C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TIME_LO,
        SEL_TIME_HI,
        SEL_ALM_LO,
        SEL_ALM_HI,
        SEL_IRQ_EN,
        SEL_ALM_STOP,
        SEL_ALM_STAT,
        SEL_IRQ_ACK
    } reg_sel_e;

    // One-cycle write strobes fanned out from the decoder
    typedef struct packed {
        logic [HALVES-1:0] time_wr;
        logic [HALVES-1:0] alarm_wr;
        logic              en_wr;
        logic              alarm_stop;
        logic              irq_ack;
    } wr_cmd_t;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        reg_sel_e s;
        case (off)
            OFF_TIME_LO:  s = SEL_TIME_LO;
            OFF_TIME_HI:  s = SEL_TIME_HI;
            OFF_ALM_LO:   s = SEL_ALM_LO;
            OFF_ALM_HI:   s = SEL_ALM_HI;
            OFF_IRQ_EN:   s = SEL_IRQ_EN;
            OFF_ALM_STOP: s = SEL_ALM_STOP;
            OFF_ALM_STAT: s = SEL_ALM_STAT;
            OFF_IRQ_ACK:  s = SEL_IRQ_ACK;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] half_of(input logic [CNT_W-1:0] v,
                                                  input int unsigned h);
        return v[h*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/rtc_regdec.sv
module rtc_regdec
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  time_now,
    input  logic [CNT_W-1:0]  alarm_word,
    input  logic              en_bit,
    input  logic              waiting,
    output wr_cmd_t           cmd,
    output logic [WORD_W-1:0] rdata
);

    reg_sel_e          which;
    logic              do_wr;
    logic              do_rd;
    logic [WORD_W-1:0] rd_mux;

    assign which = decode_offset(32'(addr));
    assign do_wr = sel && wr;
    assign do_rd = sel && !wr;

    always_comb begin
        cmd            = '0;
        cmd.time_wr[0] = do_wr && (which == SEL_TIME_LO);
        cmd.time_wr[1] = do_wr && (which == SEL_TIME_HI);
        cmd.alarm_wr[0] = do_wr && (which == SEL_ALM_LO);
        cmd.alarm_wr[1] = do_wr && (which == SEL_ALM_HI);
        cmd.en_wr      = do_wr && (which == SEL_IRQ_EN);
        cmd.alarm_stop = do_wr && (which == SEL_ALM_STOP);
        cmd.irq_ack    = do_wr && (which == SEL_IRQ_ACK);
    end

    always_comb begin
        rd_mux = '0;
        case (which)
            SEL_TIME_LO:  rd_mux = half_of(time_now, 0);
            SEL_TIME_HI:  rd_mux = half_of(time_now, 1);
            SEL_ALM_LO:   rd_mux = half_of(alarm_word, 0);
            SEL_ALM_HI:   rd_mux = half_of(alarm_word, 1);
            SEL_IRQ_EN:   rd_mux = {{(WORD_W-1){1'b0}}, en_bit};
            SEL_ALM_STAT: rd_mux = {{(WORD_W-1){1'b0}}, waiting};
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (do_rd) begin
            rdata <= rd_mux;
        end
    end

    AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (do_rd && (which == SEL_NONE || which == SEL_IRQ_ACK || which == SEL_ALM_STOP))
        |=> (rdata == '0)); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones(cmd) <= 1); // R10

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int NS_PER_CLK = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALVES-1:0] time_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  time_now
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(NS_PER_CLK);

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    // A software write freezes this cycle's increment
    assign base = (|time_wr) ? time_now : time_now + STEP;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign nxt[h*WORD_W +: WORD_W] = time_wr[h] ? wdata : base[h*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_now <= '0;
        end else begin
            time_now <= nxt;
        end
    end

    AST_STEADY_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (time_wr == '0) |=> (time_now == $past(time_now) + STEP)); // R2

    AST_LO_WR_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (time_wr == 2'b01) |=> (time_now[CNT_W-1:WORD_W] == $past(time_now[CNT_W-1:WORD_W]))); // R3

    AST_HI_WR_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        (time_wr == 2'b10) |=> (time_now[WORD_W-1:0] == $past(time_now[WORD_W-1:0]))); // R3

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  time_now,
    input  logic [HALVES-1:0] alarm_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              alarm_stop,
    input  logic              irq_ack,
    output logic [CNT_W-1:0]  alarm_word,
    output logic              waiting,
    output logic              pending
);

    logic [CNT_W-1:0] alarm_nxt;
    logic             arm;
    logic             arm_past;
    logic             reached;
    logic             event_now;
    logic             waiting_nxt;

    for (genvar h = 0; h < HALVES; h++) begin : g_store
        assign alarm_nxt[h*WORD_W +: WORD_W] =
            alarm_wr[h] ? wdata : alarm_word[h*WORD_W +: WORD_W];
    end

    // Arming happens on the low-word write, with the merged 64-bit value
    assign arm       = alarm_wr[0];
    assign arm_past  = (alarm_nxt <= time_now);
    assign reached   = waiting && (time_now >= alarm_word);
    assign event_now = arm ? arm_past : reached;

    always_comb begin
        waiting_nxt = waiting;
        if (arm) begin
            waiting_nxt = !arm_past;
        end else if (alarm_stop || reached) begin
            waiting_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_word <= '0;
            waiting    <= 1'b0;
            pending    <= 1'b0;
        end else begin
            alarm_word <= alarm_nxt;
            waiting    <= waiting_nxt;
            if (event_now) begin
                pending <= 1'b1;
            end else if (irq_ack) begin
                pending <= 1'b0;
            end
        end
    end

    AST_HI_WR_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        (alarm_wr == 2'b10) |=> (waiting == $past(waiting) || !waiting)); // R4

    AST_PAST_ARM_FIRES: assert property (@(posedge clk) disable iff (rst)
        (arm && ({alarm_word[CNT_W-1:WORD_W], wdata} <= time_now)) |=> (pending && !waiting)); // R5

    AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (rst)
        (waiting && !arm && (time_now >= alarm_word)) |=> (pending && !waiting)); // R6

    AST_STOP_CANCELS: assert property (@(posedge clk) disable iff (rst)
        alarm_stop |=> !waiting); // R8

    AST_STOP_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
        (alarm_stop && pending) |=> pending); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !waiting) |=> !pending); // R9

endmodule

// File: rtl/ns_rtc.sv
module ns_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NS_PER_CLK = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    wr_cmd_t          cmd;
    logic [CNT_W-1:0] time_now;
    logic [CNT_W-1:0] alarm_word;
    logic             waiting;
    logic             pending;
    logic             en_bit;

    rtc_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .sel        (bus_sel),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .time_now   (time_now),
        .alarm_word (alarm_word),
        .en_bit     (en_bit),
        .waiting    (waiting),
        .cmd        (cmd),
        .rdata      (bus_rdata)
    );

    rtc_counter #(.NS_PER_CLK(NS_PER_CLK)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .time_wr  (cmd.time_wr),
        .wdata    (bus_wdata),
        .time_now (time_now)
    );

    rtc_alarm_unit u_alm (
        .clk        (clk),
        .rst        (rst),
        .time_now   (time_now),
        .alarm_wr   (cmd.alarm_wr),
        .wdata      (bus_wdata),
        .alarm_stop (cmd.alarm_stop),
        .irq_ack    (cmd.irq_ack),
        .alarm_word (alarm_word),
        .waiting    (waiting),
        .pending    (pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_bit <= 1'b0;
        end else if (cmd.en_wr) begin
            en_bit <= bus_wdata[0];
        end
    end

    assign irq = pending & en_bit;

    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmd.en_wr && !bus_wdata[0]) |=> !irq); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq && !waiting && time_now == '0)); // R1

endmodule

// File: tb/ns_rtc_test.sv
module ns_rtc_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int NS         = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ns_rtc #(.ADDR_W(ADDR_W), .NS_PER_CLK(NS)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Monitor: compare registered read data one half-cycle after the sampling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s read: actual 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    // Driver tasks: each occupies exactly one clock, starting and ending at a negedge
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq: actual %0b expected %0b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        check_irq(1'b0, "R1");
        bus_read(8'h00, 32'h0, "R1");
        bus_read(8'h00, 32'd10, "R2");
        bus_read(8'h10, 32'h0, "R1");
        bus_read(8'h18, 32'h0, "R1");
        bus_read(8'h08, 32'h0, "R1");
        bus_read(8'h0C, 32'h0, "R1");

        // R3 half writes, R2 advance
        bus_write(8'h00, 32'h0000_1000);
        bus_read(8'h00, 32'h0000_1000, "R3");
        bus_read(8'h00, 32'h0000_100A, "R2");
        bus_write(8'h04, 32'h5);
        bus_read(8'h04, 32'h5, "R3");
        bus_read(8'h00, 32'h0000_101E, "R3");
        // R2 carry into upper half
        bus_write(8'h00, 32'hFFFF_FFF6);
        bus_read(8'h04, 32'h5, "R2");
        bus_read(8'h04, 32'h6, "R2");
        bus_read(8'h00, 32'h0000_000A, "R2");

        // R5 alarm in the past fires at once, masked while enable is 0
        bus_write(8'h0C, 32'h0);
        bus_write(8'h08, 32'h10);
        check_irq(1'b0, "R7");
        bus_read(8'h18, 32'h0, "R5");
        bus_read(8'h08, 32'h10, "R4");
        // R4 upper write stores only
        bus_write(8'h0C, 32'h7);
        bus_read(8'h0C, 32'h7, "R4");
        bus_read(8'h18, 32'h0, "R4");
        // R7 enable uses bit 0
        bus_write(8'h10, 32'h3);
        check_irq(1'b1, "R5");
        bus_read(8'h10, 32'h1, "R7");
        // R8 stop keeps pending
        bus_write(8'h14, 32'h0);
        check_irq(1'b1, "R8");
        // R9 ack with zero data still clears
        bus_write(8'h1C, 32'h0);
        check_irq(1'b0, "R9");
        bus_write(8'h10, 32'h2);
        bus_read(8'h10, 32'h0, "R7");
        bus_write(8'h10, 32'h1);

        // R6 future alarm fires exactly when time reaches it
        bus_write(8'h04, 32'h0);
        bus_write(8'h00, 32'h0);
        bus_write(8'h0C, 32'h0);
        bus_write(8'h08, 32'd100);
        bus_read(8'h18, 32'h1, "R6");
        idle(7);
        check_irq(1'b0, "R6");
        idle(1);
        check_irq(1'b1, "R6");
        bus_read(8'h18, 32'h0, "R6");
        bus_read(8'h08, 32'd100, "R4");
        bus_write(8'h1C, 32'hFFFF_FFFF);
        check_irq(1'b0, "R9");

        // R8 cancel stops a future event
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'd200);
        bus_read(8'h18, 32'h1, "R8");
        bus_write(8'h14, 32'h1);
        bus_read(8'h18, 32'h0, "R8");
        idle(25);
        check_irq(1'b0, "R8");

        // R9 ack on the firing edge loses to the event
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'd100);
        idle(9);
        bus_write(8'h1C, 32'h0);
        check_irq(1'b1, "R9");
        bus_write(8'h1C, 32'h0);
        check_irq(1'b0, "R9");

        // R5 alarm equal to current time fires at once
        bus_write(8'h00, 32'h500);
        bus_write(8'h08, 32'h500);
        check_irq(1'b1, "R5");
        bus_read(8'h18, 32'h0, "R5");
        bus_write(8'h1C, 32'h0);

        // R6 alarm between steps still fires
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'd105);
        idle(10);
        check_irq(1'b0, "R6");
        idle(1);
        check_irq(1'b1, "R6");
        bus_write(8'h1C, 32'h0);
        check_irq(1'b0, "R9");

        // R10 undefined offsets
        bus_write(8'h00, 32'h2000);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h00, 32'h200A, "R10");
        bus_write(8'h03, 32'h0);
        bus_read(8'h00, 32'h201E, "R10");
        bus_read(8'h20, 32'h0, "R10");
        bus_read(8'h14, 32'h0, "R10");
        bus_read(8'h1C, 32'h0, "R10");
        bus_read(8'h02, 32'h0, "R10");
        bus_read(8'h18, 32'h0, "R10");
        bus_read(8'h10, 32'h1, "R10");
        check_irq(1'b0, "R10");

        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule